// File: doc/BRIEF.md
# Transmit PLL Recalibration Sequencer

This block drives the recalibration of one transmit PLL after its line rate or reference clock has changed. It is a master on a memory-mapped reconfiguration bus. After a start pulse it claims the bus from the on-chip calibration controller and waits until that controller lets go. It then sets the calibration-request bit for the selected PLL type, hands the bus back and waits for the calibration to finish. Steps never overlap.

Each bus command holds its address, data and strobes stable while the slave stalls it. Read data is taken only in the cycle the slave marks it valid. Completion is found in one of two ways: a status register is read periodically, or an external busy line is sampled periodically. A bounded number of busy results ends the run with an error flag instead of a hang.

Top module: `pll_recal_seq`

## Requirements
- R1: While reset is active, and in the cycle after reset is asserted, `busy`, `done`, `timeout_err`, `avm_read` and `avm_write` are all low.
- R2: A `start` pulse while idle launches a sequence and raises `busy` in the next cycle. A `start` pulse while `busy` is high has no effect: no second ownership request is issued, and the PLL type captured at launch is kept.
- R3: The first bus command of a sequence is a write of 0x02 to address 0x000 with only byte lane 0 enabled (`avm_byteenable` = 4'b0001). Every write to address 0x000 uses that byte lane alone.
- R4: Bus grant is found by reading address 0x280 until bit 2 reads 0. Consecutive status reads in one phase are spaced by `POLL_GAP` idle cycles of the sequencer.
- R5: Once the grant is seen, address 0x100 is read. The read value is written back to 0x100 with all byte lanes enabled, with bit 0 set when `pll_frac`=0 or bit 1 set when `pll_frac`=1. All other bits are unchanged. Neither access happens before the grant.
- R6: After the read-modify-write, and never before it, 0x01 is written to address 0x000 (byte lane 0) to hand the bus back.
- R7: With `busy_src_ext`=0, completion is found by reading address 0x280 every `POLL_GAP` cycles until bit 1 reads 0.
- R8: With `busy_src_ext`=1, completion is found by sampling `cal_busy_in` every `POLL_GAP` cycles until it is low. No status reads are made in that phase.
- R9: While `avm_waitrequest` is high, an active read or write holds its strobe, address, write data and byte enables unchanged. `avm_readdata` is used only in a cycle where `avm_readdatavalid` is high.
- R10: On success, `done` is high for exactly one cycle, and `busy` is low in that same cycle.
- R11: If the grant phase or the completion phase gets `MAX_POLLS` busy results, the sequencer returns to idle with `timeout_err` high and `done` low. The remaining steps are skipped. `timeout_err` stays high until the next accepted `start`.
- R12: `avm_read` and `avm_write` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to run a recalibration |
| pll_frac | input | 1 | PLL type: 0 selects request bit 0, 1 selects request bit 1 |
| busy_src_ext | input | 1 | 1: watch `cal_busy_in`; 0: poll the status register |
| cal_busy_in | input | 1 | External calibration-busy line, synchronous to `clk` |
| avm_address | output | ADDR_W | Bus address |
| avm_read | output | 1 | Read strobe |
| avm_write | output | 1 | Write strobe |
| avm_writedata | output | DATA_W | Write data |
| avm_byteenable | output | DATA_W/8 | Byte lane enables |
| avm_waitrequest | input | 1 | Slave stall |
| avm_readdata | input | DATA_W | Read data |
| avm_readdatavalid | input | 1 | Read data valid strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout_err | output | 1 | Poll limit reached in the last run |

## Verification
On every cycle the assertions check the following:
- bus commands hold steady under stall;
- read and write are mutually exclusive;
- writes to the control address use the low byte lane only;
- the strobes are quiet when idle;
- `done` is a single-cycle pulse that excludes `busy` and the error flag;
- the error flag persists until a new start.

Only the bench scenarios can show the rest:
- the order of the steps;
- the exact spacing of status reads;
- the value written back, including bit preservation for each PLL type;
- that data is taken only with the valid strobe;
- the exact poll count at which each phase gives up, and that a start mid-run is ignored.

// File: rtl/prs_pkg.sv
package prs_pkg;

  // Fixed register map of the reconfiguration space
  localparam logic [11:0] CTRL_OFS     = 12'h000;
  localparam logic [11:0] PLL_CFG_OFS  = 12'h100;
  localparam logic [11:0] STATUS_OFS   = 12'h280;

  // Bit positions the calibration controller decodes
  localparam int GRANT_BUSY_BIT = 2;
  localparam int CAL_BUSY_BIT   = 1;
  localparam int INT_CAL_BIT    = 0;
  localparam int FRAC_CAL_BIT   = 1;

  // Ownership codes written into the control byte
  localparam logic [7:0] OWN_REQ_CODE = 8'h02;
  localparam logic [7:0] OWN_REL_CODE = 8'h01;

  typedef enum logic [3:0] {
    S_IDLE,
    S_REQ_BUS,
    S_GRANT_RD,
    S_GRANT_GAP,
    S_RMW_RD,
    S_RMW_WR,
    S_REL_BUS,
    S_CAL_GAP,
    S_CAL_RD
  } seq_state_e;

  typedef enum logic [1:0] {
    X_IDLE,
    X_CMD,
    X_DATA
  } xact_state_e;

endpackage

// File: rtl/prs_rst_sync.sv
module prs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/prs_avmm_xact.sv
// Single-transaction bus engine: latches one command, holds it through
// stalls, and reports completion on acceptance (write) or valid data (read).
module prs_avmm_xact
  import prs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              ack,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] avm_address,
  output logic              avm_read,
  output logic              avm_write,
  output logic [DATA_W-1:0] avm_writedata,
  output logic [BE_W-1:0]   avm_byteenable,
  input  logic              avm_waitrequest,
  input  logic [DATA_W-1:0] avm_readdata,
  input  logic              avm_readdatavalid
);

  xact_state_e       state_q, state_d;
  logic              is_rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic              cap_en;

  assign cap_en = (state_q == X_IDLE) && (req_rd || req_wr);

  always_comb begin
    state_d = state_q;
    ack     = 1'b0;
    unique case (state_q)
      X_IDLE: begin
        if (req_rd || req_wr) state_d = X_CMD;
      end
      X_CMD: begin
        if (!avm_waitrequest) begin
          if (is_rd_q) begin
            state_d = X_DATA;
          end else begin
            state_d = X_IDLE;
            ack     = 1'b1;
          end
        end
      end
      X_DATA: begin
        if (avm_readdatavalid) begin
          state_d = X_IDLE;
          ack     = 1'b1;
        end
      end
      default: state_d = X_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= X_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_rd_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (cap_en) begin
      is_rd_q <= req_rd;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  assign avm_address    = addr_q;
  assign avm_writedata  = wdata_q;
  assign avm_byteenable = be_q;
  assign avm_read       = (state_q == X_CMD) && is_rd_q;
  assign avm_write      = (state_q == X_CMD) && !is_rd_q;
  assign rsp_data       = avm_readdata;

endmodule

// File: rtl/prs_gap_timer.sv
module prs_gap_timer #(
  parameter int GAP = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int CNT_W = (GAP > 1) ? $clog2(GAP) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(GAP - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/prs_poll_limit.sv
module prs_poll_limit #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic at_limit
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (bump) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_limit = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/pll_recal_seq.sv
module pll_recal_seq
  import prs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int POLL_GAP  = 16,
  parameter int MAX_POLLS = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  pll_frac,
  input  logic                  busy_src_ext,
  input  logic                  cal_busy_in,
  output logic [ADDR_W-1:0]     avm_address,
  output logic                  avm_read,
  output logic                  avm_write,
  output logic [DATA_W-1:0]     avm_writedata,
  output logic [DATA_W/8-1:0]   avm_byteenable,
  input  logic                  avm_waitrequest,
  input  logic [DATA_W-1:0]     avm_readdata,
  input  logic                  avm_readdatavalid,
  output logic                  busy,
  output logic                  done,
  output logic                  timeout_err
);

  localparam int BE_W = DATA_W / 8;
  localparam logic [BE_W-1:0] LANE0    = BE_W'(1);
  localparam logic [BE_W-1:0] ALL_LANE = '1;

  logic              rst_sync_n;
  seq_state_e        state_q, state_d;
  logic              frac_q, ext_q;
  logic [DATA_W-1:0] rmw_q;
  logic              done_q, err_q;

  logic              req_rd, req_wr, ack;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rsp_data, cal_mask;
  logic [BE_W-1:0]   req_be;
  logic              gap_load, gap_expired;
  logic              poll_clr, poll_bump, poll_at_limit;
  logic              fin_ok, fin_err, rmw_cap, latch_cfg;

  prs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  prs_avmm_xact #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_xact (
    .clk               (clk),
    .rst_n             (rst_sync_n),
    .req_rd            (req_rd),
    .req_wr            (req_wr),
    .req_addr          (req_addr),
    .req_wdata         (req_wdata),
    .req_be            (req_be),
    .ack               (ack),
    .rsp_data          (rsp_data),
    .avm_address       (avm_address),
    .avm_read          (avm_read),
    .avm_write         (avm_write),
    .avm_writedata     (avm_writedata),
    .avm_byteenable    (avm_byteenable),
    .avm_waitrequest   (avm_waitrequest),
    .avm_readdata      (avm_readdata),
    .avm_readdatavalid (avm_readdatavalid)
  );

  prs_gap_timer #(.GAP(POLL_GAP)) u_gap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (gap_load),
    .expired (gap_expired)
  );

  prs_poll_limit #(.LIMIT(MAX_POLLS)) u_limit (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (poll_clr),
    .bump     (poll_bump),
    .at_limit (poll_at_limit)
  );

  assign cal_mask = DATA_W'(1) << (frac_q ? FRAC_CAL_BIT : INT_CAL_BIT);

  // Next-state and command decode
  always_comb begin
    state_d   = state_q;
    req_rd    = 1'b0;
    req_wr    = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    req_be    = ALL_LANE;
    gap_load  = 1'b0;
    poll_clr  = 1'b0;
    poll_bump = 1'b0;
    fin_ok    = 1'b0;
    fin_err   = 1'b0;
    rmw_cap   = 1'b0;
    latch_cfg = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          latch_cfg = 1'b1;
          poll_clr  = 1'b1;
          state_d   = S_REQ_BUS;
        end
      end
      S_REQ_BUS: begin
        req_wr    = 1'b1;
        req_addr  = ADDR_W'(CTRL_OFS);
        req_wdata = DATA_W'(OWN_REQ_CODE);
        req_be    = LANE0;
        if (ack) state_d = S_GRANT_RD;
      end
      S_GRANT_RD: begin
        req_rd   = 1'b1;
        req_addr = ADDR_W'(STATUS_OFS);
        if (ack) begin
          if (!rsp_data[GRANT_BUSY_BIT]) begin
            state_d = S_RMW_RD;
          end else if (poll_at_limit) begin
            fin_err = 1'b1;
            state_d = S_IDLE;
          end else begin
            poll_bump = 1'b1;
            gap_load  = 1'b1;
            state_d   = S_GRANT_GAP;
          end
        end
      end
      S_GRANT_GAP: begin
        if (gap_expired) state_d = S_GRANT_RD;
      end
      S_RMW_RD: begin
        req_rd   = 1'b1;
        req_addr = ADDR_W'(PLL_CFG_OFS);
        if (ack) begin
          rmw_cap = 1'b1;
          state_d = S_RMW_WR;
        end
      end
      S_RMW_WR: begin
        req_wr    = 1'b1;
        req_addr  = ADDR_W'(PLL_CFG_OFS);
        req_wdata = rmw_q;
        if (ack) state_d = S_REL_BUS;
      end
      S_REL_BUS: begin
        req_wr    = 1'b1;
        req_addr  = ADDR_W'(CTRL_OFS);
        req_wdata = DATA_W'(OWN_REL_CODE);
        req_be    = LANE0;
        if (ack) begin
          poll_clr = 1'b1;
          gap_load = 1'b1;
          state_d  = S_CAL_GAP;
        end
      end
      S_CAL_GAP: begin
        if (gap_expired) begin
          if (!ext_q) begin
            state_d = S_CAL_RD;
          end else if (!cal_busy_in) begin
            fin_ok  = 1'b1;
            state_d = S_IDLE;
          end else if (poll_at_limit) begin
            fin_err = 1'b1;
            state_d = S_IDLE;
          end else begin
            poll_bump = 1'b1;
            gap_load  = 1'b1;
          end
        end
      end
      S_CAL_RD: begin
        req_rd   = 1'b1;
        req_addr = ADDR_W'(STATUS_OFS);
        if (ack) begin
          if (!rsp_data[CAL_BUSY_BIT]) begin
            fin_ok  = 1'b1;
            state_d = S_IDLE;
          end else if (poll_at_limit) begin
            fin_err = 1'b1;
            state_d = S_IDLE;
          end else begin
            poll_bump = 1'b1;
            gap_load  = 1'b1;
            state_d   = S_CAL_GAP;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      frac_q <= 1'b0;
      ext_q  <= 1'b0;
    end else if (latch_cfg) begin
      frac_q <= pll_frac;
      ext_q  <= busy_src_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rmw_q <= '0;
    end else if (rmw_cap) begin
      rmw_q <= rsp_data | cal_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q <= 1'b0;
    end else if (latch_cfg) begin
      err_q <= 1'b0;
    end else if (fin_err) begin
      err_q <= 1'b1;
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;

endmodule

// File: rtl/prs_seq_chk.sv
module prs_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                timeout_err,
  input logic [ADDR_W-1:0]   avm_address,
  input logic                avm_read,
  input logic                avm_write,
  input logic [DATA_W-1:0]   avm_writedata,
  input logic [DATA_W/8-1:0] avm_byteenable,
  input logic                avm_waitrequest
);

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(avm_read && avm_write)); // R12

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    avm_read && avm_waitrequest |=> avm_read && $stable(avm_address)); // R9

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    avm_write && avm_waitrequest |=> avm_write && $stable(avm_address)
      && $stable(avm_writedata) && $stable(avm_byteenable)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !avm_read && !avm_write); // R1

  AST_CTRL_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    avm_write && (avm_address == '0) |-> avm_byteenable == (DATA_W/8)'(1)); // R3

  AST_DONE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !timeout_err); // R11

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err && !start |=> timeout_err); // R11

endmodule

bind pll_recal_seq prs_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start           (start),
  .busy            (busy),
  .done            (done),
  .timeout_err     (timeout_err),
  .avm_address     (avm_address),
  .avm_read        (avm_read),
  .avm_write       (avm_write),
  .avm_writedata   (avm_writedata),
  .avm_byteenable  (avm_byteenable),
  .avm_waitrequest (avm_waitrequest)
);

// File: tb/pll_recal_seq_tb.sv
module pll_recal_seq_tb;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int GAP    = 3;
  localparam int LIM    = 4;

  typedef struct packed {
    logic        frac;
    logic        ext;
    logic [3:0]  stall;
    logic [7:0]  g;
    logic [7:0]  c;
    logic [31:0] init;
    logic        to;
  } vec_t;

  localparam int N_VEC = 8;
  localparam vec_t VECS [N_VEC] = '{
    '{1'b0, 1'b0, 4'd0, 8'd0, 8'd0,   32'h0000_0000, 1'b0},
    '{1'b1, 1'b0, 4'd2, 8'd2, 8'd3,   32'hA5A5_5A58, 1'b0},
    '{1'b0, 1'b0, 4'd1, 8'd1, 8'd1,   32'hFFFF_FFFE, 1'b0},
    '{1'b1, 1'b1, 4'd0, 8'd0, 8'd5,   32'h1234_5670, 1'b0},
    '{1'b0, 1'b0, 4'd0, 8'd0, 8'd4,   32'h0000_0008, 1'b1},
    '{1'b0, 1'b1, 4'd1, 8'd3, 8'd2,   32'h0F0F_0F00, 1'b0},
    '{1'b1, 1'b0, 4'd1, 8'd6, 8'd0,   32'h0000_0000, 1'b1},
    '{1'b1, 1'b0, 4'd0, 8'd3, 8'd0,   32'h8000_0001, 1'b0}
  };

  logic clk, rst_n, start, pll_frac, busy_src_ext, cal_busy_in;
  logic [ADDR_W-1:0] avm_address;
  logic avm_read, avm_write, avm_waitrequest, avm_readdatavalid;
  logic [DATA_W-1:0] avm_writedata, avm_readdata;
  logic [3:0] avm_byteenable;
  logic busy, done, timeout_err;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // slave configuration, written only by the stimulus process
  logic        cfg_load = 1'b0;
  int          cfg_stall = 0, cfg_g = 0, cfg_c = 0;
  logic [31:0] cfg_init = '0;

  // slave model state
  logic [31:0] ctrl_q, pll_q, rdd_s1, rdd_s2;
  logic        rdv_s1, rdv_s2, rmw_seen;
  int grant_left, cal_left, ext_left, stall_left, last_stat;
  int req_wr_n, rel_wr_n, grant_rd_n, cal_rd_n, done_n;
  int spacing_bad, order_bad, be_bad, rw_both;

  pll_recal_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_GAP(GAP),
                  .MAX_POLLS(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_frac(pll_frac),
    .busy_src_ext(busy_src_ext), .cal_busy_in(cal_busy_in),
    .avm_address(avm_address), .avm_read(avm_read), .avm_write(avm_write),
    .avm_writedata(avm_writedata), .avm_byteenable(avm_byteenable),
    .avm_waitrequest(avm_waitrequest), .avm_readdata(avm_readdata),
    .avm_readdatavalid(avm_readdatavalid), .busy(busy), .done(done),
    .timeout_err(timeout_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign avm_waitrequest   = (avm_read || avm_write) && (stall_left != 0);
  assign avm_readdatavalid = rdv_s2;
  assign avm_readdata      = rdv_s2 ? rdd_s2 : '0;   // garbage-free zero when not valid
  assign cal_busy_in       = (ext_left != 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cfg_load) begin
      ctrl_q <= '0; pll_q <= cfg_init; rdd_s1 <= '0; rdd_s2 <= '0;
      rdv_s1 <= 1'b0; rdv_s2 <= 1'b0; rmw_seen <= 1'b0;
      grant_left <= cfg_g; cal_left <= cfg_c; ext_left <= 0;
      stall_left <= cfg_stall; last_stat <= -1;
      req_wr_n <= 0; rel_wr_n <= 0; grant_rd_n <= 0; cal_rd_n <= 0; done_n <= 0;
      spacing_bad <= 0; order_bad <= 0; be_bad <= 0; rw_both <= 0;
    end else begin
      rdv_s2 <= rdv_s1; rdd_s2 <= rdd_s1; rdv_s1 <= 1'b0;
      if (done) done_n <= done_n + 1;
      if (avm_read && avm_write) rw_both <= rw_both + 1;
      if (ext_left != 0) ext_left <= ext_left - 1;
      if (avm_read || avm_write) begin
        if (stall_left != 0) begin
          stall_left <= stall_left - 1;
        end else begin
          stall_left <= cfg_stall;
          if (avm_write) begin
            last_stat <= -1;
            if (avm_address == 10'h000) begin
              if (avm_byteenable != 4'b0001) be_bad <= be_bad + 1;
              ctrl_q <= {ctrl_q[31:8], avm_writedata[7:0]};
              if (avm_writedata[7:0] == 8'h02) req_wr_n <= req_wr_n + 1;
              if (avm_writedata[7:0] == 8'h01) begin
                rel_wr_n <= rel_wr_n + 1;
                ext_left <= cfg_c;
                if (!rmw_seen) order_bad <= order_bad + 1;
              end
            end else if (avm_address == 10'h100) begin
              if (avm_byteenable != 4'b1111) be_bad <= be_bad + 1;
              if (ctrl_q[7:0] != 8'h02 || grant_left != 0) order_bad <= order_bad + 1;
              pll_q <= avm_writedata;
              rmw_seen <= 1'b1;
            end
          end else begin
            rdv_s1 <= 1'b1;
            rdd_s1 <= '0;
            if (avm_address == 10'h280) begin
              rdd_s1 <= {29'd0, (ctrl_q[7:0] == 8'h02) && (grant_left != 0),
                         (ctrl_q[7:0] == 8'h01) && (cal_left != 0), 1'b0};
              if (ctrl_q[7:0] == 8'h02) begin
                grant_rd_n <= grant_rd_n + 1;
                if (grant_left != 0) grant_left <= grant_left - 1;
              end else if (ctrl_q[7:0] == 8'h01) begin
                cal_rd_n <= cal_rd_n + 1;
                if (cal_left != 0) cal_left <= cal_left - 1;
              end
              // R4/R7 spacing: GAP idle cycles plus fixed command/response cycles
              if (last_stat >= 0 && (cyc - last_stat) != GAP + 4 + cfg_stall)
                spacing_bad <= spacing_bad + 1;
              last_stat <= cyc;
            end else if (avm_address == 10'h100) begin
              if (ctrl_q[7:0] != 8'h02 || grant_left != 0) order_bad <= order_bad + 1;
              rdd_s1 <= pll_q;
            end
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input int stall, input int g, input int c,
                          input logic [31:0] init);
    @(negedge clk);
    cfg_stall = stall; cfg_g = g; cfg_c = c; cfg_init = init; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic pulse_start(input logic frac, input logic ext);
    @(negedge clk);
    pll_frac = frac; busy_src_ext = ext; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 3000 && busy; n++) @(negedge clk);
  endtask

  task automatic finish_run();
    tests++;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pll_frac = 1'b0; busy_src_ext = 1'b0;
    load_cfg(0, 0, 0, 32'h0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy in reset", 64'(busy), 0);
    chk(done == 1'b0, "R1 done in reset", 64'(done), 0);
    chk(timeout_err == 1'b0, "R1 err in reset", 64'(timeout_err), 0);
    chk(!avm_read && !avm_write, "R1 strobes in reset", 64'({avm_read, avm_write}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table walk
    for (int i = 0; i < N_VEC; i++) begin
      automatic vec_t v = VECS[i];
      automatic bit gto = (v.g >= LIM);
      automatic logic [31:0] exp_pll = gto ? v.init
                                           : (v.init | (v.frac ? 32'h2 : 32'h1));
      automatic int exp_grd = (v.g + 1 < LIM) ? v.g + 1 : LIM;
      automatic int exp_crd = (gto || v.ext) ? 0 : ((v.c + 1 < LIM) ? v.c + 1 : LIM);
      load_cfg(int'(v.stall), int'(v.g), int'(v.c), v.init);
      pulse_start(v.frac, v.ext);
      chk(busy == 1'b1, $sformatf("R2 busy after start v%0d", i), 64'(busy), 1);
      wait_idle();
      chk(done == !v.to, $sformatf("R10 done at end v%0d", i), 64'(done), 64'(!v.to));
      chk(timeout_err == v.to, $sformatf("R11 err v%0d", i), 64'(timeout_err), 64'(v.to));
      @(negedge clk);
      chk(done_n == (v.to ? 0 : 1), $sformatf("R10 done width v%0d", i), 64'(done_n), 64'(!v.to));
      chk(req_wr_n == 1 && be_bad == 0, $sformatf("R3 request write v%0d", i),
          64'(req_wr_n), 1);
      chk(grant_rd_n == exp_grd, $sformatf("R4 grant reads v%0d", i), 64'(grant_rd_n), 64'(exp_grd));
      chk(spacing_bad == 0, $sformatf("R4 R7 read spacing v%0d", i), 64'(spacing_bad), 0);
      chk(pll_q == exp_pll, $sformatf("R5 R9 pll cfg v%0d", i), 64'(pll_q), 64'(exp_pll));
      chk(rel_wr_n == (gto ? 0 : 1) && order_bad == 0, $sformatf("R6 release v%0d", i),
          64'(rel_wr_n), 64'(!gto));
      chk(cal_rd_n == exp_crd, $sformatf("R7 R8 cal reads v%0d", i), 64'(cal_rd_n), 64'(exp_crd));
      chk(rw_both == 0, $sformatf("R12 rw overlap v%0d", i), 64'(rw_both), 0);
    end

    // R2: start while busy is ignored, including its PLL type
    load_cfg(1, 2, 1, 32'h0000_0010);
    pulse_start(1'b0, 1'b0);
    repeat (5) @(negedge clk);
    pulse_start(1'b1, 1'b1);
    wait_idle();
    @(negedge clk);
    chk(req_wr_n == 1, "R2 no second request", 64'(req_wr_n), 1);
    chk(done_n == 1, "R2 single done", 64'(done_n), 1);
    chk(pll_q == 32'h0000_0011, "R2 type kept", 64'(pll_q), 64'h11);

    // R1: reset in the middle of a run
    load_cfg(1, 3, 3, 32'h0);
    pulse_start(1'b1, 1'b0);
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 mid-run reset flags",
        64'({busy, done}), 0);
    chk(!avm_read && !avm_write, "R1 mid-run reset strobes",
        64'({avm_read, avm_write}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: error clears on a new start that succeeds
    load_cfg(0, 0, 9, 32'h0);
    pulse_start(1'b0, 1'b0);
    wait_idle();
    chk(timeout_err == 1'b1, "R11 cal timeout", 64'(timeout_err), 1);
    load_cfg(0, 0, 0, 32'h0);
    pulse_start(1'b0, 1'b0);
    chk(timeout_err == 1'b0, "R11 err cleared at start", 64'(timeout_err), 0);
    wait_idle();
    chk(done == 1'b1, "R10 done after clear", 64'(done), 1);

    tests--;
    finish_run();
  end

endmodule